// File: doc/BRIEF.md
# I2C Byte-Step Master

This block is an I2C bus master that software walks through a transfer one bus phase at a time. Software writes a 16-bit command word that packs the address or data byte with control bits. The engine then performs exactly one phase: a START followed by the address byte, one transmitted data byte, one received data byte, or a STOP. After each address or data phase it raises an event, asserts the interrupt and holds SCL low. The bus stays frozen until software issues the next command with the event-clear bit set. That handshake lets an interrupt handler make every decision on the bus: continue, issue a repeated START, or stop.

The register port is byte-wide. Offset 0 is status, with bit 3 the target acknowledge, bit 2 the direction and bit 5 a STOP seen on the bus. Offset 1 holds the events and errors, with bit 4 the phase event and bit 6 a command that arrived while a phase was running. Offset 2 holds the received byte. Offset 5 stages the upper command byte. A write to offset 4 supplies the lower command byte and executes the full word. Offset 12 holds the clock divider N. SCL and SDA are open-drain: the block only drives them low, and both inputs pass through a two-flop synchronizer.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, SCL and SDA are released, irq is low, status and event registers read 0 and the divider reads 20.
- R2: A START command (cmd bit 0) in idle produces a START condition, then sends cmd[15:9] and the direction bit cmd[2] MSB first. After the acknowledge slot, event bit 4 is set and irq goes high.
- R3: While the event is pending, SCL stays held low. In the hold state, a command without the clear bit (cmd bit 7) is ignored.
- R4: A data command (bit 7 set, bits 1:0 clear, bit 2 clear) sends cmd[15:8]. Status bit 3 is 1 when the target acknowledged the last address or written byte and 0 on NACK.
- R5: A data command with bit 2 set shifts in 8 bits MSB first into register 2. In the ninth slot it drives ACK (SDA low) when cmd bit 3 is set and leaves SDA released (NACK) otherwise.
- R6: A START command with bit 7 set, issued in the hold state, produces a repeated START with no STOP before it.
- R7: A STOP command (bits 7 and 1) in the hold state raises SDA while SCL is high and then releases both lines. Status bit 5 is set when a STOP is seen on the bus and cleared by the next START command.
- R8: The SCL period is 4·N·CLK_PER_QREF clocks plus at most 4 clocks of synchronizer wait. Each high phase lasts at least two quarters, because the engine waits until the bus is seen high, even when a target stretches the clock.
- R9: SDA changes only while SCL is low, except for START and STOP conditions.
- R10: A command written while a phase is running is ignored and sets event bit 6. irq stays high while any event or error bit is set.
- R11: Writing 0 to the event register clears all its bits and drops irq. A nonzero write to it changes nothing.
- R12: Status bit 2 reports the direction bit of the most recent START command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | High while any event or error bit is set |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong phase counter or shift register shows within one byte time: the target model receives a corrupted address or data byte, or the event lands a slot early or late and the scoreboard order breaks. A wrong hold or stretch state shows as SCL released while the event is pending, or as an SCL high time shorter than two quarters, within one SCL period. Bad acknowledge or direction bookkeeping shows on the next status read after the event. A spurious SDA edge while SCL is high shows as an extra START or STOP counted by the target.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter int CLK_PER_QREF = 6,
  parameter int DIV_RST      = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int TW = 8 + $clog2(CLK_PER_QREF + 1);
  localparam logic [3:0] A_STAT = 4'd0, A_EVT = 4'd1, A_RXD = 4'd2,
                         A_CMDL = 4'd4, A_CMDH = 4'd5, A_DIV = 4'd12;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_STA, S_BYTE, S_STO} st_t;
  st_t st;

  logic [1:0] qph;
  logic [3:0] bitn;
  logic [7:0] sh, rxd, cmd_hi, div;
  logic [TW-1:0] tcnt, reload;
  logic rd, ack_en, is_addr, smp;
  logic stat_ack, stat_dir, stat_stop, ev_m, ev_err;
  logic [1:0] scl_sync, sda_sync;
  logic sda_d, scl_s, sda_s;
  logic scl_c, sda_c;

  assign scl_s = scl_sync[1];
  assign sda_s = sda_sync[1];

  logic [15:0] cword;
  logic wr_cmd, busy, go_start, go_stop, go_data, cmd_err, tick, stretch, byte_done, cond_phase;

  assign cword    = {cmd_hi, reg_wdata};
  assign wr_cmd   = reg_wr && reg_addr == A_CMDL;
  assign busy     = st == S_STA || st == S_BYTE || st == S_STO;
  assign cond_phase = st == S_STA || st == S_STO;
  assign go_start = wr_cmd && cword[0] && (st == S_IDLE || (st == S_HOLD && cword[7]));
  assign go_stop  = wr_cmd && !cword[0] && cword[1] && st == S_HOLD && cword[7];
  assign go_data  = wr_cmd && cword[1:0] == 2'b00 && st == S_HOLD && cword[7];
  assign cmd_err  = wr_cmd && busy;

  assign reload   = TW'(div == 8'd0 ? 8'd1 : div) * TW'(CLK_PER_QREF) - 1'b1;
  assign stretch  = !scl_c && !scl_s;
  assign tick     = busy && tcnt == '0 && !stretch;
  assign byte_done = tick && st == S_BYTE && qph == 2'd3 && bitn == 4'd8;

  always_comb begin
    scl_c = 1'b0;
    sda_c = 1'b0;
    case (st)
      S_HOLD: scl_c = 1'b1;
      S_STA: begin
        scl_c = qph == 2'd3;
        sda_c = qph >= 2'd2;
      end
      S_BYTE: begin
        scl_c = qph < 2'd2;
        sda_c = (bitn < 4'd8) ? (!(rd && !is_addr) && !sh[7]) : (rd && !is_addr && ack_en);
      end
      S_STO: begin
        scl_c = qph == 2'd0;
        sda_c = qph < 2'd2;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      sda_d    <= 1'b1;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      sda_d    <= sda_s;
      scl_oe   <= scl_c;
      sda_oe   <= sda_c;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_hi <= '0;
      div    <= 8'(DIV_RST);
      ev_m   <= 1'b0;
      ev_err <= 1'b0;
      stat_stop <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CMDH) cmd_hi <= reg_wdata;
      if (reg_wr && reg_addr == A_DIV) div <= reg_wdata;
      if (reg_wr && reg_addr == A_EVT && reg_wdata == 8'd0) begin
        ev_m   <= 1'b0;
        ev_err <= 1'b0;
      end else begin
        if (wr_cmd && cword[7] && !busy) ev_m <= 1'b0;
        if (byte_done) ev_m <= 1'b1;
        if (cmd_err) ev_err <= 1'b1;
      end
      if (go_start) stat_stop <= 1'b0;
      else if (scl_s && sda_s && !sda_d) stat_stop <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      qph <= '0;
      bitn <= '0;
      sh <= '0;
      rxd <= '0;
      rd <= 1'b0;
      ack_en <= 1'b0;
      is_addr <= 1'b0;
      smp <= 1'b0;
      stat_ack <= 1'b0;
      stat_dir <= 1'b0;
      tcnt <= '0;
    end else begin
      if (!busy || stretch || tcnt == '0) tcnt <= reload;
      else tcnt <= tcnt - 1'b1;
      if (go_start) begin
        st <= S_STA;
        qph <= '0;
        sh <= {cmd_hi[7:1], cword[2]};
        rd <= cword[2];
        stat_dir <= cword[2];
        is_addr <= 1'b1;
      end else if (go_data) begin
        st <= S_BYTE;
        qph <= '0;
        bitn <= '0;
        is_addr <= 1'b0;
        rd <= cword[2];
        ack_en <= cword[3];
        sh <= cword[2] ? 8'hFF : cmd_hi;
      end else if (go_stop) begin
        st <= S_STO;
        qph <= '0;
      end else if (tick) begin
        qph <= qph + 1'b1;
        case (st)
          S_STA: if (qph == 2'd3) begin
            st <= S_BYTE;
            bitn <= '0;
          end
          S_BYTE: begin
            if (qph == 2'd2) smp <= sda_s;
            if (qph == 2'd3) begin
              if (bitn == 4'd8) begin
                st <= S_HOLD;
                if (rd && !is_addr) rxd <= sh;
                else stat_ack <= !smp;
              end else begin
                sh <= {sh[6:0], smp};
                bitn <= bitn + 1'b1;
              end
            end
          end
          S_STO: if (qph == 2'd3) st <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {2'b00, stat_stop, 1'b0, stat_ack, stat_dir, 2'b00};
      A_EVT:   reg_rdata = {1'b0, ev_err, 1'b0, ev_m, 4'b0000};
      A_RXD:   reg_rdata = rxd;
      A_DIV:   reg_rdata = div;
      default: reg_rdata = 8'd0;
    endcase
  end

  assign irq = ev_m | ev_err;
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       reg_wr,
  input logic       irq,
  input logic       scl_oe,
  input logic       ev_m,
  input logic       ev_err,
  input logic       busy,
  input logic       cond_phase,
  input logic       scl_c,
  input logic       sda_c
);
  // R3
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_m && !(reg_wr && reg_addr == 4'd4)) |=> scl_oe);

  // R9
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_c && !$past(scl_c) && sda_c != $past(sda_c)) |-> (cond_phase || $past(cond_phase)));

  // R10
  busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd4 && busy) |=> ev_err);

  // R11
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd1 && reg_wdata == 8'd0) |=> !irq);
endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .irq(irq), .scl_oe(scl_oe), .ev_m(ev_m), .ev_err(ev_err),
  .busy(busy), .cond_phase(cond_phase), .scl_c(scl_c), .sda_c(sda_c)
);

// File: tb/i2c_step_master_test.sv
module i2c_step_master_test;
  localparam int PRE = 6;
  localparam logic [6:0] TGT = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic reg_wr = 1'b0;
  logic irq, scl_oe, sda_oe;
  logic t_scl_low, t_sda_low;
  wire scl = !(scl_oe || t_scl_low);
  wire sda = !(sda_oe || t_sda_low);

  int nchk = 0, nfail = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  i2c_step_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sb_pop(input logic [7:0] got);
    logic [8:0] e;
    if (exp_q.size() == 0) begin
      chk(0, "R4 unexpected byte on bus", int'(got), 0);
    end else begin
      e = exp_q.pop_front();
      chk(got == e[7:0], e[8] ? "R2 address byte" : "R4 data byte", int'(got), int'(e[7:0]));
    end
  endtask

  // target model and bus monitor
  logic ps, pd, t_act, t_fresh, t_addr, t_rdm, t_match, m_ack, stretch_en;
  int bitn, rd_idx, n_start, n_stop, str_cnt, cyc, last_rise, last_per, min_high;
  logic [7:0] sh, tx;
  logic [7:0] rd_data [2];
  initial begin
    rd_data[0] = 8'hC3;
    rd_data[1] = 8'h96;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ps <= 1'b1; pd <= 1'b1; t_act <= 1'b0; t_fresh <= 1'b0; t_addr <= 1'b0;
      t_rdm <= 1'b0; t_match <= 1'b0; m_ack <= 1'b0; bitn <= 0; rd_idx <= 0;
      n_start <= 0; n_stop <= 0; str_cnt <= 0; sh <= '0; tx <= '0;
      t_scl_low <= 1'b0; t_sda_low <= 1'b0;
      cyc <= 0; last_rise <= 0; last_per <= 0; min_high <= 1000000;
    end else begin
      cyc <= cyc + 1;
      ps <= scl;
      pd <= sda;
      if (!ps && scl) begin
        last_per <= cyc - last_rise;
        last_rise <= cyc;
      end
      if (ps && !scl && (cyc - last_rise) < min_high) min_high <= cyc - last_rise;
      if (str_cnt > 0) begin
        str_cnt <= str_cnt - 1;
        if (str_cnt == 1) t_scl_low <= 1'b0;
      end
      if (ps && scl && pd && !sda) begin
        n_start <= n_start + 1;
        t_act <= 1'b1; t_fresh <= 1'b1; t_addr <= 1'b1; t_rdm <= 1'b0;
        bitn <= 0; t_sda_low <= 1'b0;
      end else if (ps && scl && !pd && sda) begin
        n_stop <= n_stop + 1;
        t_act <= 1'b0;
        t_sda_low <= 1'b0;
      end else if (t_act && !ps && scl) begin
        if (bitn < 8) sh <= {sh[6:0], sda};
        else if (t_rdm) m_ack <= !sda;
      end else if (t_act && ps && !scl) begin
        if (t_fresh) begin
          t_fresh <= 1'b0;
        end else if (bitn < 7) begin
          bitn <= bitn + 1;
          if (t_rdm) begin
            t_sda_low <= !tx[6];
            tx <= tx << 1;
          end
          if (stretch_en && bitn == 3 && !t_rdm) begin
            t_scl_low <= 1'b1;
            str_cnt <= 100;
          end
        end else if (bitn == 7) begin
          bitn <= 8;
          if (t_rdm) t_sda_low <= 1'b0;
          else begin
            sb_pop(sh);
            if (t_addr) begin
              t_match <= sh[7:1] == TGT;
              t_sda_low <= sh[7:1] == TGT;
              t_rdm <= sh[0] && sh[7:1] == TGT;
            end else t_sda_low <= sh != 8'hEE;
          end
        end else begin
          bitn <= 0;
          t_addr <= 1'b0;
          t_sda_low <= 1'b0;
          if (!t_match) t_act <= 1'b0;
          else if (t_rdm && (t_addr || m_ack)) begin
            t_sda_low <= !rd_data[rd_idx % 2][7];
            tx <= rd_data[rd_idx % 2];
            rd_idx <= rd_idx + 1;
          end
        end
      end
    end
  end

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic cmd(input logic [7:0] hi, input logic [7:0] lo);
    wreg(4'd5, hi);
    wreg(4'd4, lo);
  endtask

  task automatic wait_evt();
    logic [7:0] v;
    rreg(4'd1, v);
    while (!v[4]) rreg(4'd1, v);
  endtask

  task automatic send(input logic [7:0] hi, input logic [7:0] lo, input bit is_addr);
    exp_q.push_back({is_addr, hi});
    cmd(hi, lo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int stops_before;
    stretch_en = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(irq == 0, "R1 irq low", irq, 0);
    rreg(4'd12, v); chk(v == 8'd20, "R1 divider reset", v, 20);
    rreg(4'd0, v);  chk(v == 8'd0, "R1 status reset", v, 0);
    rreg(4'd1, v);  chk(v == 8'd0, "R1 event reset", v, 0);

    wreg(4'd12, 8'd2);
    // R2 address phase, write direction
    send({TGT, 1'b0}, 8'h01, 1'b1);
    wait_evt();
    chk(last_per >= 4*2*PRE && last_per <= 4*2*PRE + 4, "R8 SCL period N=2", last_per, 4*2*PRE);
    rreg(4'd1, v); chk(v == 8'h10, "R2 event bit after address", v, 8'h10);
    chk(irq == 1, "R2 irq high", irq, 1);
    rreg(4'd0, v);
    chk(v[3] == 1, "R4 address ACK status", v[3], 1);
    chk(v[2] == 0, "R12 direction write", v[2], 0);
    // R3 commands without clear bit are ignored while held
    wreg(4'd4, 8'h00);
    wreg(4'd4, 8'h01);
    repeat (100) @(negedge clk);
    chk(scl_oe == 1, "R3 SCL held", scl_oe, 1);
    rreg(4'd1, v); chk(v == 8'h10, "R3 event still pending", v, 8'h10);
    chk(exp_q.size() == 0, "R3 no byte sent while held", exp_q.size(), 0);

    // R4 data writes with ACK and NACK
    send(8'h3C, 8'h80, 1'b0);
    wait_evt();
    rreg(4'd0, v); chk(v[3] == 1, "R4 data ACK status", v[3], 1);
    send(8'hEE, 8'h80, 1'b0);
    wait_evt();
    rreg(4'd0, v); chk(v[3] == 0, "R4 data NACK status", v[3], 0);

    // R10 command during a running phase
    send(8'h5A, 8'h80, 1'b0);
    repeat (20) @(negedge clk);
    wreg(4'd4, 8'h80);
    wait_evt();
    rreg(4'd1, v); chk(v == 8'h50, "R10 busy error bit", v, 8'h50);
    chk(irq == 1, "R10 irq with error", irq, 1);
    // R11
    wreg(4'd1, 8'h10);
    rreg(4'd1, v); chk(v == 8'h50, "R11 nonzero write ignored", v, 8'h50);
    wreg(4'd1, 8'h00);
    rreg(4'd1, v); chk(v == 8'h00, "R11 zero write clears", v, 0);
    chk(irq == 0, "R11 irq dropped", irq, 0);
    chk(scl_oe == 1, "R3 SCL held after clear", scl_oe, 1);

    // R6 repeated start into a read
    stops_before = n_stop;
    send({TGT, 1'b1}, 8'h85, 1'b1);
    wait_evt();
    rreg(4'd0, v);
    chk(v[2] == 1, "R12 direction read", v[2], 1);
    chk(v[3] == 1, "R4 read address ACK", v[3], 1);
    // R5
    cmd(8'h00, 8'h8C);
    wait_evt();
    rreg(4'd2, v); chk(v == 8'hC3, "R5 first read byte", v, 8'hC3);
    chk(m_ack == 1, "R5 master ACK driven", m_ack, 1);
    cmd(8'h00, 8'h84);
    wait_evt();
    rreg(4'd2, v); chk(v == 8'h96, "R5 last read byte", v, 8'h96);
    chk(m_ack == 0, "R5 master NACK on last", m_ack, 0);
    chk(n_stop == stops_before, "R6 no STOP before repeated START", n_stop, stops_before);

    // R7 stop
    cmd(8'h00, 8'h82);
    repeat (200) @(negedge clk);
    chk(n_stop == stops_before + 1, "R7 STOP seen on bus", n_stop, stops_before + 1);
    chk(scl_oe == 0 && sda_oe == 0, "R7 lines released", {scl_oe, sda_oe}, 0);
    rreg(4'd0, v); chk(v[5] == 1, "R7 stop status", v[5], 1);

    // address NACK with divider 3
    wreg(4'd12, 8'd3);
    send(8'h22, 8'h01, 1'b1);
    rreg(4'd0, v); chk(v[5] == 0, "R7 stop status cleared by START", v[5], 0);
    wait_evt();
    chk(last_per >= 4*3*PRE && last_per <= 4*3*PRE + 4, "R8 SCL period N=3", last_per, 4*3*PRE);
    rreg(4'd0, v); chk(v[3] == 0, "R4 address NACK status", v[3], 0);
    cmd(8'h00, 8'h82);
    repeat (300) @(negedge clk);

    // clock stretching by the target
    stretch_en = 1'b1;
    send({TGT, 1'b0}, 8'h01, 1'b1);
    wait_evt();
    send(8'h81, 8'h80, 1'b0);
    wait_evt();
    rreg(4'd0, v); chk(v[3] == 1, "R4 ACK after stretched byte", v[3], 1);
    cmd(8'h00, 8'h82);
    repeat (300) @(negedge clk);

    chk(min_high >= 2*2*PRE, "R8 SCL high time kept under stretch", min_high, 2*2*PRE);
    chk(exp_q.size() == 0, "R4 all expected bytes seen", exp_q.size(), 0);
    // R9 every SDA edge at SCL high is a requested START or STOP
    chk(n_start == 4 && n_stop == 3, "R9 START/STOP count", n_start*16 + n_stop, 4*16 + 3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule